// File: doc/BRIEF.md
# LED Blink Timer with Auto-Stop

This block drives one LED with a programmable blink pattern. A free-running prescaler produces a tick every 2^n clock cycles, where n is an exponent held in the control register. A phase counter advances on each tick and wraps at a programmed period. The LED is lit while the phase is below a programmed on-time and dark for the rest of the period.

Software can also arm an auto-stop. A working copy of a programmed blink count is loaded when the timer is started, and it drops by one at the end of every period. When that copy runs out, the block clears its own enable, holds the LED dark and raises a pending interrupt. The interrupt output shows the pending flag unless the mask bit in the control register is set.

The register interface is a plain single-cycle write port with a combinational read-back of the selected word. Words sit at byte offsets 0x0, 0x4, 0x8 and 0xC, decoded from address bits [3:2].

Top module: `blink_timer`

## Requirements
- R1: After reset, `led_o` and `irq_o` are 0 and all four registers read back as 0.
- R2: The control word at 0x0 keeps 7 bits: exponent in [3:0], enable in bit 4, auto-stop in bit 5 and interrupt mask in bit 6. The period at 0x4 and the on-time at 0x8 keep 12 bits each, and the blink count at 0xC keeps 16 bits. Bits above a register's width read as 0.
- R3: An exponent written above 13 is stored and read back as 13. Values 0 to 13 are stored unchanged.
- R4: Writing the control word with enable=1, exponent n, period P and on-time O < P starts a blink with `led_o` high from the cycle after the write. The LED is high for O·2^n cycles and then low for (P−O)·2^n cycles, and this repeats.
- R5: When the on-time is equal to or larger than the period, `led_o` stays high for as long as the timer is enabled.
- R6: While the enable bit is 0, `led_o` is 0.
- R7: With auto-stop set and blink count N ≥ 1, the enable bit reads 0 once N·P·2^n cycles have passed since the start. From that cycle on, `led_o` is 0 and the interrupt is pending. A count of 0 acts as 1.
- R8: `irq_o` equals the pending flag AND NOT the mask bit (bit 6). Clearing the mask by a write with enable=0 exposes a flag that is already pending.
- R9: A control-word write with enable=1 clears the pending interrupt and restarts the pattern at the start of a period, even when written in the middle of a period. It also reloads the blink count.
- R10: With auto-stop clear, the blink continues past the programmed count and the enable bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | 4 | Byte address of the register word (bits [3:2] select) |
| req_wr | input | 1 | Write strobe, one cycle per write |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data of the word at `req_addr` (combinational) |
| led_o | output | 1 | LED drive, 1 = lit |
| irq_o | output | 1 | Interrupt, pending flag gated by the mask |

## Verification
The bench compares the LED cycle by cycle against patterns computed from n, P and O, including prescaled cases. An off-by-one in the prescaler or in the phase wrap would stretch or shift the pattern. It times the auto-stop to the exact cycle and tries a count of zero: a design that decrements before it compares would stop one period early or late, or never stop on zero. It rewrites the control word mid-period, masks and then unmasks a pending interrupt, and writes exponents above the limit. These catch a restart that resumes the old phase, an unmask that loses the flag, and an exponent that wraps instead of clamping.

// File: rtl/blink_pkg.sv
package blink_pkg;
    localparam int EXP_W  = 4;
    localparam int CTRL_W = 7;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PER  = 2'd1,
        SEL_ON   = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    // Control word layout as seen by software: [6]=mask [5]=auto [4]=en [3:0]=exp
    typedef struct packed {
        logic             msk;
        logic             auto_stop;
        logic             en;
        logic [EXP_W-1:0] exp;
    } ctrl_t;
endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler #(
    parameter int MAX_EXP = 13,
    localparam int PRE_W  = (MAX_EXP > 0) ? MAX_EXP : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic                      clear_i,
    input  logic [blink_pkg::EXP_W-1:0] exp_i,
    output logic                      tick_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(exp_i));
        end
        tick_o = run_i && ((s_q.cnt & mask) == mask);
        s_d = s_q;
        if (clear_i || !run_i) s_d.cnt = '0;
        else                   s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: the register stage must never hand over an unclamped exponent
    assert_exp_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(exp_i) <= MAX_EXP);
endmodule

// File: rtl/blink_phase.sv
module blink_phase #(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PER_W-1:0] on_i,
    output logic             wrap_o,
    output logic             lit_o
);
    typedef struct packed {
        logic [PER_W-1:0] ph;
    } phase_t;

    phase_t s_d, s_q;
    logic   last;

    always_comb begin
        last   = ({1'b0, s_q.ph} + 1'b1) >= {1'b0, period_i};
        wrap_o = run_i && !clear_i && tick_i && last;
        lit_o  = (s_q.ph < on_i) || (on_i >= period_i);
        s_d    = s_q;
        if (clear_i || !run_i) s_d.ph = '0;
        else if (tick_i)       s_d.ph = last ? '0 : s_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: the phase only moves on a prescaler tick
    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !clear_i) |=> $stable(s_q.ph));
endmodule

// File: rtl/blink_autostop.sv
module blink_autostop #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             arm_i,
    input  logic             wrap_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } rem_t;

    rem_t s_d, s_q;

    always_comb begin
        expire_o = arm_i && wrap_i && (s_q.rem <= CNT_W'(1));
        s_d      = s_q;
        if (load_i)                s_d.rem = load_val_i;
        else if (expire_o)         s_d.rem = '0;
        else if (arm_i && wrap_i)  s_d.rem = s_q.rem - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: once expired, the owner drops the arm, so no second expiry follows
    assert_single_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !load_i) |=> !expire_o);
endmodule

// File: rtl/blink_timer.sv
module blink_timer #(
    parameter int PER_W   = 12,
    parameter int CNT_W   = 16,
    parameter int MAX_EXP = 13,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              led_o,
    output logic              irq_o
);
    import blink_pkg::*;

    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(MAX_EXP);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] on;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } regs_t;

    regs_t    s_d, s_q;
    reg_sel_e sel;
    logic     ctrl_wr, start, tick, wrap, lit, expire;

    always_comb begin
        sel     = reg_sel_e'(req_addr[3:2]);
        ctrl_wr = req_wr && (sel == SEL_CTRL);
        start   = ctrl_wr && req_wdata[4];
        s_d     = s_q;
        if (expire) begin
            s_d.ctrl.en = 1'b0;
            s_d.irq     = 1'b1;
        end
        if (req_wr) begin
            case (sel)
                SEL_CTRL: begin
                    s_d.ctrl.exp       = (req_wdata[EXP_W-1:0] > EXP_LIM) ? EXP_LIM
                                                                           : req_wdata[EXP_W-1:0];
                    s_d.ctrl.en        = req_wdata[4];
                    s_d.ctrl.auto_stop = req_wdata[5];
                    s_d.ctrl.msk       = req_wdata[6];
                    if (req_wdata[4]) s_d.irq = 1'b0;
                end
                SEL_PER: s_d.per = req_wdata[PER_W-1:0];
                SEL_ON:  s_d.on  = req_wdata[PER_W-1:0];
                default: s_d.cnt = req_wdata[CNT_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rd_data = DATA_W'(s_q.ctrl);
            SEL_PER:  rd_data = DATA_W'(s_q.per);
            SEL_ON:   rd_data = DATA_W'(s_q.on);
            default:  rd_data = DATA_W'(s_q.cnt);
        endcase
    end

    blink_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (s_q.ctrl.en),
        .clear_i (start),
        .exp_i   (s_q.ctrl.exp),
        .tick_o  (tick)
    );

    blink_phase #(.PER_W(PER_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (s_q.ctrl.en),
        .clear_i  (start),
        .tick_i   (tick),
        .period_i (s_q.per),
        .on_i     (s_q.on),
        .wrap_o   (wrap),
        .lit_o    (lit)
    );

    blink_autostop #(.CNT_W(CNT_W)) u_stop (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_val_i (s_q.cnt),
        .arm_i      (s_q.ctrl.en && s_q.ctrl.auto_stop),
        .wrap_i     (wrap),
        .expire_o   (expire)
    );

    assign led_o = s_q.ctrl.en & lit;
    assign irq_o = s_q.irq & ~s_q.ctrl.msk;

    // R7: an enable that drops without a software write must leave an interrupt pending
    assert_stop_sets_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.ctrl.en) && !$past(ctrl_wr)) |-> s_q.irq);

    // R6: a disabled timer keeps the LED dark
    assert_dark_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.ctrl.en |-> !led_o);

    // R8: a masked block never drives the interrupt
    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ctrl.msk |-> !irq_o);
endmodule

// File: tb/tb_blink_timer.sv
module tb_blink_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req_addr = '0;
    logic        req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        led_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    blink_timer dut (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wr(req_wr),
        .req_wdata(req_wdata), .rd_data(rd_data), .led_o(led_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // write; returns at the negedge after the write edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        req_addr = a; req_wdata = d; req_wr = 1'b1;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [3:0] a, input int expv, input string tag);
        req_addr = a;
        #1;
        chk(tag, int'(rd_data), expv);
    endtask

    task automatic setup(input int per, input int on, input int cnt);
        wr(4'h4, 16'(per));
        wr(4'h8, 16'(on));
        wr(4'hC, 16'(cnt));
    endtask

    // called at sample 0 (negedge right after the start write)
    task automatic follow(input int n, input int per, input int on, input int periods, input string tag);
        int tot;
        tot = periods * per * (1 << n);
        for (int i = 0; i < tot; i++) begin
            int expv;
            if (i > 0) @(negedge clk);
            expv = (on >= per || ((i >> n) % per) < on) ? 1 : 0;
            chk(tag, int'(led_o), expv);
        end
    endtask

    task automatic t_reset;
        chk("R1 led", int'(led_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        for (int a = 0; a < 4; a++) rd_now(4'(a * 4), 0, "R1 reg");
    endtask

    task automatic t_widths;
        wr(4'h4, 16'hFFFF); rd_now(4'h4, 16'h0FFF, "R2 period");
        wr(4'h8, 16'hFFFF); rd_now(4'h8, 16'h0FFF, "R2 on");
        wr(4'hC, 16'hABCD); rd_now(4'hC, 16'hABCD, "R2 count");
        wr(4'h0, 16'hFF80); rd_now(4'h0, 16'h0000, "R2 ctrl");
    endtask

    task automatic t_clamp;
        wr(4'h0, 16'h000E); rd_now(4'h0, 16'h000D, "R3 clamp14");
        wr(4'h0, 16'h000F); rd_now(4'h0, 16'h000D, "R3 clamp15");
        wr(4'h0, 16'h0009); rd_now(4'h0, 16'h0009, "R3 keep9");
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_blink(input int n, input int per, input int on);
        setup(per, on, 0);
        wr(4'h0, 16'(16'h0010 | n));
        follow(n, per, on, 2, "R4 pattern");
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_solid;
        setup(4, 4, 0);
        wr(4'h0, 16'h0010);
        follow(0, 4, 4, 3, "R5 on==period");
        wr(4'h8, 16'd9);
        follow(0, 4, 9, 3, "R5 on>period");
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_disable;
        setup(4, 2, 0);
        wr(4'h0, 16'h0010);
        wr(4'h0, 16'h0000);
        for (int i = 0; i < 20; i++) begin
            chk("R6 dark", int'(led_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_autostop(input int n, input int per, input int on, input int cnt);
        int t;
        t = ((cnt == 0) ? 1 : cnt) * per * (1 << n);
        setup(per, on, cnt);
        wr(4'h0, 16'(16'h0030 | n));
        for (int i = 1; i < t; i++) begin
            @(negedge clk);
            chk("R7 irq before stop", int'(irq_o), 0);
        end
        @(negedge clk);
        chk("R7 led after stop", int'(led_o), 0);
        chk("R7 irq after stop", int'(irq_o), 1);
        rd_now(4'h0, 16'(16'h0020 | n), "R7 enable cleared");
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R7 led held off", int'(led_o), 0);
        end
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_mask;
        setup(2, 1, 1);
        wr(4'h0, 16'h0070);
        repeat (2) @(negedge clk);
        chk("R8 masked irq", int'(irq_o), 0);
        rd_now(4'h0, 16'h0060, "R8 stopped while masked");
        wr(4'h0, 16'h0020);
        chk("R8 unmask shows pending", int'(irq_o), 1);
        wr(4'h0, 16'h0010);
        chk("R9 start clears irq", int'(irq_o), 0);
        chk("R9 led lit at start", int'(led_o), 1);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_restart;
        setup(6, 3, 0);
        wr(4'h0, 16'h0010);
        repeat (3) @(negedge clk);
        wr(4'h0, 16'h0010);
        follow(0, 6, 3, 1, "R9 restart phase");
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_noauto;
        setup(2, 1, 1);
        wr(4'h0, 16'h0010);
        follow(0, 2, 1, 10, "R10 keeps running");
        rd_now(4'h0, 16'h0010, "R10 enable stays");
        chk("R10 no irq", int'(irq_o), 0);
        wr(4'h0, 16'h0000);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_widths();
        t_clamp();
        t_blink(0, 5, 2);
        t_blink(1, 4, 1);
        t_blink(2, 3, 2);
        t_solid();
        t_disable();
        t_autostop(1, 3, 1, 2);
        t_autostop(0, 4, 2, 0);
        t_mask();
        t_restart();
        t_noauto();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule